// File: doc/BRIEF.md
# Multiplexed Numeric Display Refresh Controller

This block holds a sixteen-digit decimal number and refreshes a multiplexed numeric display one digit position at a time. In each digit slot it presents an encoded position on `dig_sel` and the four-bit decimal value of that position on `bcd_out`. These feed an external position decoder and an external segment decoder. The scan starts at the most significant position and walks down to position 0, then begins the next frame. Each slot lasts a programmable number of clock cycles.

Software-side logic writes digits one at a time into a staging copy of the number. It writes the decimal-point position and the memory and sign indicator flags the same way. Staged values, and the slot length on `dwell_cycles`, are copied into the displayed copy only at a frame boundary, so a frame never shows a half-written number. Leading zeros are replaced by the dark code 4'hF. Suppression ends at the first nonzero digit or at the digit that carries the decimal point, whichever comes first. Position 0 is always shown. A blanking request darkens the whole display, indicators included, while the scan keeps running.

Top module: `disp_mux_ctrl`

## Requirements
- R1: While `rst_n` is low, `dig_sel` is 15, `bcd_out` is 4'hF and all three indicator outputs are low.
- R2: A pulse on `wr_en` stores `wr_data` as staged digit `wr_addr` (0 is least significant). A pulse on `cfg_wr` stages the decimal-point enable, the decimal-point position and the two indicator flags. Staged values and `dwell_cycles` take effect together at the next frame start, and a write during a frame leaves that frame's output unchanged.
- R3: `dig_sel` steps down by one from 15 to 0. After the slot of position 0 it returns to 15, which starts a new frame.
- R4: Each slot lasts `dwell_cycles` clock cycles, or one cycle when `dwell_cycles` is 0.
- R5: A displayed digit of value 0 that lies above the most significant nonzero digit is output as 4'hF.
- R6: When the decimal point is enabled, the digit at the decimal-point position and every digit below it are shown even when they are zero.
- R7: Position 0 is never suppressed; it shows its digit whenever the display is not blanked.
- R8: One clock cycle after `blank_req` is high, `bcd_out` is 4'hF and all indicators are low, while `dig_sel` keeps scanning.
- R9: `ind_dp` is high only during the slot whose `dig_sel` equals the committed decimal-point position, only when the decimal point is enabled, and only while not blanked.
- R10: `ind_mem` and `ind_sign` follow the committed memory and sign flags for the whole frame while not blanked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Digit write strobe |
| wr_addr | input | 4 | Digit position to write |
| wr_data | input | 4 | Digit value to write |
| cfg_wr | input | 1 | Strobe that stages the decimal point and flags |
| cfg_dp_en | input | 1 | Decimal point enable |
| cfg_dp_pos | input | 4 | Decimal point position |
| cfg_mem | input | 1 | Memory indicator flag |
| cfg_sign | input | 1 | Sign indicator flag |
| dwell_cycles | input | 8 | Clock cycles per digit slot (0 acts as 1) |
| blank_req | input | 1 | Blank the whole display |
| dig_sel | output | 4 | Encoded digit position being shown |
| bcd_out | output | 4 | Digit value, 4'hF when dark |
| ind_mem | output | 1 | Memory indicator |
| ind_sign | output | 1 | Sign indicator |
| ind_dp | output | 1 | Decimal point indicator |

## Verification
On every cycle, the assertions check the following:
- the scan steps down by one or wraps to 15, and the slot counter stays inside the slot length;
- the displayed copy changes only at a frame boundary;
- a blank request darkens every output on the following cycle;
- position 0 is never darkened by suppression.

Only the bench scenarios can show whether the chosen digits are the right ones for a given number and decimal-point position. The same holds for the exact slot length for a committed dwell value, and for a write in mid-frame appearing one frame later rather than at once.

// File: rtl/disp_pkg.sv
package disp_pkg;
  localparam int unsigned DIGIT_W = 4;
  typedef logic [DIGIT_W-1:0] digit_t;
  localparam digit_t DARK_CODE = 4'hF;

  function automatic logic digit_is_zero(input digit_t d);
    return d == '0;
  endfunction

  function automatic logic [7:0] slot_len(input logic [7:0] dwell);
    return (dwell == '0) ? 8'd1 : dwell;
  endfunction
endpackage

// File: rtl/disp_regs.sv
module disp_regs
  import disp_pkg::*;
#(
  parameter int unsigned NDIG  = 16,
  parameter int unsigned SELW  = 4,
  parameter int unsigned DWW   = 8,
  parameter int unsigned RST_DWELL = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [SELW-1:0]       wr_addr,
  input  digit_t                wr_data,
  input  logic                  cfg_wr,
  input  logic                  cfg_dp_en,
  input  logic [SELW-1:0]       cfg_dp_pos,
  input  logic                  cfg_mem,
  input  logic                  cfg_sign,
  input  logic [DWW-1:0]        dwell_in,
  input  logic                  commit,
  output logic [NDIG*DIGIT_W-1:0] act_digits,
  output logic                  act_dp_en,
  output logic [SELW-1:0]       act_dp_pos,
  output logic                  act_mem,
  output logic                  act_sign,
  output logic [DWW-1:0]        act_dwell
);
  localparam int unsigned FLATW = NDIG * DIGIT_W;

  digit_t stage_q [NDIG];
  logic   st_dp_en, st_mem, st_sign;
  logic [SELW-1:0] st_dp_pos;

  for (genvar g = 0; g < NDIG; g++) begin : g_digit
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stage_q[g] <= '0;
        act_digits[g*DIGIT_W +: DIGIT_W] <= '0;
      end else begin
        if (wr_en && wr_addr == SELW'(g)) stage_q[g] <= wr_data;
        if (commit) act_digits[g*DIGIT_W +: DIGIT_W] <= stage_q[g];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_dp_en   <= 1'b0;
      st_dp_pos  <= '0;
      st_mem     <= 1'b0;
      st_sign    <= 1'b0;
      act_dp_en  <= 1'b0;
      act_dp_pos <= '0;
      act_mem    <= 1'b0;
      act_sign   <= 1'b0;
      act_dwell  <= DWW'(RST_DWELL);
    end else begin
      if (cfg_wr) begin
        st_dp_en  <= cfg_dp_en;
        st_dp_pos <= cfg_dp_pos;
        st_mem    <= cfg_mem;
        st_sign   <= cfg_sign;
      end
      if (commit) begin
        act_dp_en  <= st_dp_en;
        act_dp_pos <= st_dp_pos;
        act_mem    <= st_mem;
        act_sign   <= st_sign;
        act_dwell  <= dwell_in;
      end
    end
  end

  // R2: the displayed copy moves only at a frame boundary
  a_r2_frozen_mid_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(act_digits) && $stable(act_dp_en) && $stable(act_dp_pos)
                 && $stable(act_mem) && $stable(act_sign) && $stable(act_dwell)));

  logic unused_w;
  assign unused_w = ^FLATW;
endmodule

// File: rtl/disp_scan.sv
module disp_scan
  import disp_pkg::*;
#(
  parameter int unsigned NDIG = 16,
  parameter int unsigned SELW = 4,
  parameter int unsigned DWW  = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DWW-1:0]  hold,
  output logic [SELW-1:0] sel,
  output logic            frame_end
);
  localparam logic [SELW-1:0] TOP_SEL = SELW'(NDIG - 1);

  logic [DWW-1:0] cnt;
  logic [DWW-1:0] len;
  logic           slot_end;

  assign len       = DWW'(slot_len(8'(hold)));
  assign slot_end  = (cnt == len - 1'b1);
  assign frame_end = slot_end && (sel == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel <= TOP_SEL;
      cnt <= '0;
    end else if (slot_end) begin
      cnt <= '0;
      sel <= (sel == '0) ? TOP_SEL : sel - 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R3: the position steps down by one or wraps to the top
  a_r3_sel_step: assert property (@(posedge clk) disable iff (!rst_n)
    (sel != $past(sel)) |-> ((sel == $past(sel) - 1'b1) ||
                            ($past(sel) == '0 && sel == TOP_SEL)));
  // R3: a frame end is followed by the top position
  a_r3_wrap_top: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (sel == TOP_SEL));
  // R4: the slot counter stays below the slot length
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < len);
endmodule

// File: rtl/disp_zsup.sv
module disp_zsup
  import disp_pkg::*;
#(
  parameter int unsigned NDIG = 16,
  parameter int unsigned SELW = 4
) (
  input  logic [NDIG*DIGIT_W-1:0] digits,
  input  logic                    dp_en,
  input  logic [SELW-1:0]         dp_pos,
  output logic [NDIG-1:0]         dark_mask
);
  function automatic logic [NDIG-1:0] lead_mask(
    input logic [NDIG*DIGIT_W-1:0] d,
    input logic                    en,
    input logic [SELW-1:0]         pos
  );
    logic [NDIG-1:0] m;
    logic            leading;
    m = '0;
    leading = 1'b1;
    for (int i = NDIG - 1; i >= 0; i--) begin
      if (leading && i != 0 && digit_is_zero(d[i*DIGIT_W +: DIGIT_W]) &&
          !(en && pos == SELW'(i)))
        m[i] = 1'b1;
      else
        leading = 1'b0;
    end
    return m;
  endfunction

  assign dark_mask = lead_mask(digits, dp_en, dp_pos);
endmodule

// File: rtl/disp_mux_ctrl.sv
module disp_mux_ctrl
  import disp_pkg::*;
#(
  parameter int unsigned NDIG      = 16,
  parameter int unsigned SELW      = 4,
  parameter int unsigned DWW       = 8,
  parameter int unsigned RST_DWELL = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [SELW-1:0] wr_addr,
  input  logic [3:0]      wr_data,
  input  logic            cfg_wr,
  input  logic            cfg_dp_en,
  input  logic [SELW-1:0] cfg_dp_pos,
  input  logic            cfg_mem,
  input  logic            cfg_sign,
  input  logic [DWW-1:0]  dwell_cycles,
  input  logic            blank_req,
  output logic [SELW-1:0] dig_sel,
  output logic [3:0]      bcd_out,
  output logic            ind_mem,
  output logic            ind_sign,
  output logic            ind_dp
);
  logic [NDIG*DIGIT_W-1:0] act_digits;
  logic                    act_dp_en, act_mem, act_sign;
  logic [SELW-1:0]         act_dp_pos;
  logic [DWW-1:0]          act_dwell;
  logic                    frame_end;
  logic [NDIG-1:0]         dark_mask;
  logic                    blank_q;
  digit_t                  cur_digit;

  disp_regs #(.NDIG(NDIG), .SELW(SELW), .DWW(DWW), .RST_DWELL(RST_DWELL)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cfg_wr(cfg_wr), .cfg_dp_en(cfg_dp_en), .cfg_dp_pos(cfg_dp_pos),
    .cfg_mem(cfg_mem), .cfg_sign(cfg_sign), .dwell_in(dwell_cycles),
    .commit(frame_end),
    .act_digits(act_digits), .act_dp_en(act_dp_en), .act_dp_pos(act_dp_pos),
    .act_mem(act_mem), .act_sign(act_sign), .act_dwell(act_dwell)
  );

  disp_scan #(.NDIG(NDIG), .SELW(SELW), .DWW(DWW)) u_scan (
    .clk(clk), .rst_n(rst_n), .hold(act_dwell),
    .sel(dig_sel), .frame_end(frame_end)
  );

  disp_zsup #(.NDIG(NDIG), .SELW(SELW)) u_zsup (
    .digits(act_digits), .dp_en(act_dp_en), .dp_pos(act_dp_pos),
    .dark_mask(dark_mask)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) blank_q <= 1'b1;
    else        blank_q <= blank_req;
  end

  assign cur_digit = act_digits[dig_sel*DIGIT_W +: DIGIT_W];
  assign bcd_out   = (blank_q || dark_mask[dig_sel]) ? DARK_CODE : cur_digit;
  assign ind_dp    = !blank_q && act_dp_en && (act_dp_pos == dig_sel);
  assign ind_mem   = !blank_q && act_mem;
  assign ind_sign  = !blank_q && act_sign;

  // R8: a blank request darkens everything on the next cycle
  a_r8_blank_dark: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(blank_req) && $past(rst_n)) |-> (bcd_out == DARK_CODE && !ind_dp && !ind_mem && !ind_sign));
  // R7: position 0 is never darkened by suppression
  a_r7_lsd_shown: assert property (@(posedge clk) disable iff (!rst_n)
    (dig_sel == '0 && !blank_q) |-> !dark_mask[0]);
  // R9: decimal point only in its own slot
  a_r9_dp_slot: assert property (@(posedge clk) disable iff (!rst_n)
    ind_dp |-> (dig_sel == act_dp_pos && act_dp_en));
endmodule

// File: tb/disp_mux_ctrl_test.sv
module disp_mux_ctrl_test;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, cfg_wr = 1'b0, cfg_dp_en = 1'b0, cfg_mem = 1'b0, cfg_sign = 1'b0;
  logic [3:0] wr_addr = '0, wr_data = '0, cfg_dp_pos = '0;
  logic [7:0] dwell_cycles = 8'd1;
  logic blank_req = 1'b0;
  logic [3:0] dig_sel, bcd_out;
  logic ind_mem, ind_sign, ind_dp;

  int total = 0;
  int bad = 0;

  // staged and shown models
  int s_dig [N];
  int a_dig [N];
  int s_dp_en, s_dp_pos, s_mem, s_sign, a_dp_en, a_dp_pos, a_mem, a_sign, a_dwell;
  int m_blank;

  always #2.5ns clk = ~clk;

  disp_mux_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cfg_wr(cfg_wr), .cfg_dp_en(cfg_dp_en), .cfg_dp_pos(cfg_dp_pos),
    .cfg_mem(cfg_mem), .cfg_sign(cfg_sign), .dwell_cycles(dwell_cycles),
    .blank_req(blank_req), .dig_sel(dig_sel), .bcd_out(bcd_out),
    .ind_mem(ind_mem), .ind_sign(ind_sign), .ind_dp(ind_dp)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // highest position that must be shown: first nonzero or the decimal point
  function automatic int top_shown();
    for (int i = N - 1; i > 0; i--)
      if (a_dig[i] != 0 || (a_dp_en != 0 && a_dp_pos == i)) return i;
    return 0;
  endfunction

  function automatic int exp_bcd(input int pos);
    if (m_blank != 0) return 15;
    if (pos > top_shown()) return 15;
    return a_dig[pos];
  endfunction

  task automatic put_digit(input int a, input int v);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = 4'(v);
    @(negedge clk);
    wr_en = 1'b0;
    s_dig[a] = v;
  endtask

  task automatic put_cfg(input int en, input int pos, input int mem, input int sgn);
    cfg_wr = 1'b1; cfg_dp_en = 1'(en); cfg_dp_pos = 4'(pos);
    cfg_mem = 1'(mem); cfg_sign = 1'(sgn);
    @(negedge clk);
    cfg_wr = 1'b0;
    s_dp_en = en; s_dp_pos = pos; s_mem = mem; s_sign = sgn;
  endtask

  task automatic put_number(input int v [N]);
    for (int i = 0; i < N; i++) put_digit(i, v[i]);
  endtask

  task automatic sync_frame();
    logic [3:0] prev;
    @(negedge clk);
    prev = dig_sel;
    forever begin
      @(negedge clk);
      if (prev == 4'd0 && dig_sel == 4'(N - 1)) break;
      prev = dig_sel;
    end
    for (int i = 0; i < N; i++) a_dig[i] = s_dig[i];
    a_dp_en = s_dp_en; a_dp_pos = s_dp_pos; a_mem = s_mem; a_sign = s_sign;
    a_dwell = int'(dwell_cycles);
  endtask

  // checks one full frame; mid=1 writes digit 15 halfway through (R2)
  task automatic check_frame(input int mid, input string tag);
    int h;
    int e;
    sync_frame();
    h = (a_dwell == 0) ? 1 : a_dwell;
    for (int d = N - 1; d >= 0; d--) begin
      for (int k = 0; k < h; k++) begin
        e = exp_bcd(d);
        chk(dig_sel == 4'(d), "R3 scan order", int'(dig_sel), d);
        chk(bcd_out == 4'(e), (d == 0) ? "R7 lsd" : tag, int'(bcd_out), e);
        chk(ind_dp == ((m_blank == 0) && a_dp_en != 0 && a_dp_pos == d),
            "R9 dp", int'(ind_dp), int'((m_blank == 0) && a_dp_en != 0 && a_dp_pos == d));
        chk(ind_mem == ((m_blank == 0) && a_mem != 0), "R10 mem", int'(ind_mem),
            int'((m_blank == 0) && a_mem != 0));
        chk(ind_sign == ((m_blank == 0) && a_sign != 0), "R10 sign", int'(ind_sign),
            int'((m_blank == 0) && a_sign != 0));
        if (mid != 0 && d == 8 && k == 0) begin
          wr_en = 1'b1; wr_addr = 4'd15; wr_data = 4'd7;
          s_dig[15] = 7;
        end
        @(negedge clk);
        wr_en = 1'b0;
      end
    end
    chk(dig_sel == 4'(N - 1), "R4 slot length", int'(dig_sel), N - 1);
  endtask

  int num [N];

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    for (int i = 0; i < N; i++) begin s_dig[i] = 0; a_dig[i] = 0; end
    s_dp_en = 0; s_dp_pos = 0; s_mem = 0; s_sign = 0;
    m_blank = 0;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(dig_sel == 4'd15, "R1 reset sel", int'(dig_sel), 15);
    chk(bcd_out == 4'hF, "R1 reset bcd", int'(bcd_out), 15);
    chk({ind_mem, ind_sign, ind_dp} == 3'b000, "R1 reset ind", int'({ind_mem, ind_sign, ind_dp}), 0);
    rst_n = 1'b1;

    // R5 R7: all zeros, only position 0 shows
    dwell_cycles = 8'd1;
    check_frame(0, "R5 all zero");

    // R5: nonzero at position 3
    for (int i = 0; i < N; i++) num[i] = 0;
    num[3] = 1; num[2] = 2; num[1] = 0; num[0] = 5;
    put_number(num);
    dwell_cycles = 8'd2;
    check_frame(0, "R5 lead zeros");

    // R6: decimal point above the first nonzero digit
    for (int i = 0; i < N; i++) num[i] = 0;
    num[0] = 5;
    put_number(num);
    put_cfg(1, 6, 1, 0);
    dwell_cycles = 8'd3;
    check_frame(0, "R6 dp stop");

    // R6 R7: decimal point at position 0 with zero value
    num[0] = 0;
    put_number(num);
    put_cfg(1, 0, 0, 1);
    dwell_cycles = 8'd0; // R4: zero acts as one
    check_frame(0, "R6 dp at 0");

    // R2: a write in mid-frame is not shown in that frame
    put_cfg(0, 0, 1, 1);
    dwell_cycles = 8'd2;
    check_frame(1, "R2 mid frame");
    check_frame(0, "R2 next frame");

    // R8: blanking with a full number and flags set
    for (int i = 0; i < N; i++) num[i] = (i % 9) + 1;
    put_number(num);
    put_cfg(1, 4, 1, 1);
    blank_req = 1'b1; m_blank = 1;
    check_frame(0, "R8 blank frame");
    blank_req = 1'b0; m_blank = 0;
    @(negedge clk);
    chk(bcd_out != 4'hF, "R8 unblank", int'(bcd_out), 0);
    blank_req = 1'b1;
    @(negedge clk);
    chk(bcd_out == 4'hF && !ind_mem && !ind_sign, "R8 next cycle", int'(bcd_out), 15);
    blank_req = 1'b0;

    // random frames
    for (int f = 0; f < 24; f++) begin
      int z;
      z = $urandom % (N + 1);
      for (int i = 0; i < N; i++)
        num[i] = (i >= N - z) ? 0 : int'($urandom % 10);
      put_number(num);
      put_cfg(int'($urandom % 2), int'($urandom % N), int'($urandom % 2), int'($urandom % 2));
      dwell_cycles = 8'($urandom % 5);
      m_blank = (($urandom % 5) == 0) ? 1 : 0;
      blank_req = 1'(m_blank);
      check_frame(int'($urandom % 3 == 0), "R5 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule